// File: doc/BRIEF.md
# SPI Register and Strobe Slave

This block is the serial control front end of a radio transceiver. An external host talks to it over a four-wire SPI link (mode 0, active-low select). Every transaction opens with a header byte that holds a read/write flag, a burst flag and a six-bit address. Depending on the address and the burst flag, the header then selects a configuration register (single or auto-incrementing burst access), a read-only identification/status register, a command strobe, or the write port of the transmit FIFO.

While any byte is clocked in, the block shifts a byte back. For the header and for every byte of a write, this is a chip status byte that summarises readiness, the radio state (idle or transmitting) and the transmit FIFO fill level. For the data bytes of a read, it is the requested register value. Command strobes leave the link as one-clock pulses for the rest of the chip, and the whole configuration register file is presented in parallel on a flat output bus.

The SPI pins are sampled in the system clock domain. The system clock must run at least eight times faster than SCLK.

Top module: `spi_regstrobe_slave`

## Requirements
- R1: Bits are shifted most significant bit first. MOSI is sampled on rising SCLK edges and MISO changes after falling edges, so bit 7 of each returned byte is valid before the first rising edge of that byte.
- R2: Header bit 7 selects read (1) or write (0), bit 6 is the burst flag and bits 5:0 are the address. A non-burst access to configuration addresses 0x00..0x2E moves exactly one data byte. Any further bytes in that transaction are ignored and return the status byte.
- R3: In a burst access the header address loads a counter that advances by one after each data byte, so successive data bytes write or read successive configuration registers.
- R4: The byte returned during the header, and during every data byte of a write, is the status byte: bit 7 = 0 (ready), bits 6:4 = radio state (0 idle, 2 transmitting), bits 3:0 = TX FIFO fill level saturated at 15.
- R5: A read header with the burst flag set and an address in 0x30..0x3D reads one status register: 0x30 returns 0x00, 0x31 returns 0x14, 0x35 returns 0x01 when idle and 0x13 when transmitting, and 0x3A returns the TX FIFO fill level. Further bytes in that transaction return the status byte.
- R6: A header with the burst flag clear and an address in 0x30..0x3D is a command strobe. 0x35 enters transmit and 0x36 returns to idle. Each strobe gives exactly one one-clock pulse on its output.
- R7: System reset and the reset strobe (0x30) restore every configuration register i to the value i XOR 0xA5, set the state to idle and empty the TX FIFO.
- R8: The flush strobe (0x3B) empties the TX FIFO and pulses only when the state is idle. In transmit it has no effect.
- R9: Writes to address 0x3F, single or burst, go to the TX FIFO and give one fifo_wr_valid pulse per byte. The address does not advance. The FIFO holds 64 bytes, and bytes written when it is full are dropped without a pulse.
- R10: Raising chip select mid-byte aborts the transaction. The partial byte is discarded and the next transaction starts with a fresh header.
- R11: Reads of addresses with nothing behind them (0x2F, 0x3E, 0x3F and unlisted status addresses) return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| stb_reset | output | 1 | Pulse: reset strobe received |
| stb_tx | output | 1 | Pulse: enter-transmit strobe received |
| stb_idle | output | 1 | Pulse: go-idle strobe received |
| stb_flush | output | 1 | Pulse: TX FIFO flushed |
| fifo_wr_valid | output | 1 | Pulse: byte accepted into the TX FIFO |
| fifo_wr_data | output | 8 | Byte accepted into the TX FIFO |
| cfg_flat | output | NUM_CFG*8 | Configuration registers; register i on bits 8i+7..8i |

## Verification
A completed byte is decoded three system clocks after its eighth rising SCLK edge. Register writes, strobe pulses, state changes and FIFO pushes take effect at that point, and the reply for the next byte is loaded at the following falling edge. The bench therefore holds each SCLK phase for four clocks and samples MISO at the instant it raises SCLK. It reads the pulse counters, cfg_flat and the status registers only after chip select has been high for eight clocks. Status bytes returned during a long FIFO burst are predicted from the fill level after the previous byte.

// File: rtl/xcvr_spi_pkg.sv
package xcvr_spi_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int CFG_COUNT  = 47;
    localparam int TXF_DEPTH  = 64;

    localparam logic [ADDR_W-1:0] WIN_LO     = 6'h30;
    localparam logic [ADDR_W-1:0] WIN_HI     = 6'h3D;
    localparam logic [ADDR_W-1:0] FIFO_ADDR  = 6'h3F;

    localparam logic [ADDR_W-1:0] CMD_RESET  = 6'h30;
    localparam logic [ADDR_W-1:0] CMD_TX     = 6'h35;
    localparam logic [ADDR_W-1:0] CMD_IDLE   = 6'h36;
    localparam logic [ADDR_W-1:0] CMD_FLUSH  = 6'h3B;

    localparam logic [ADDR_W-1:0] SREG_PART  = 6'h30;
    localparam logic [ADDR_W-1:0] SREG_VER   = 6'h31;
    localparam logic [ADDR_W-1:0] SREG_MAIN  = 6'h35;
    localparam logic [ADDR_W-1:0] SREG_LEVEL = 6'h3A;

    localparam logic [BYTE_W-1:0] ID_PART    = 8'h00;
    localparam logic [BYTE_W-1:0] ID_VER     = 8'h14;
    localparam logic [BYTE_W-1:0] MAIN_IDLE  = 8'h01;
    localparam logic [BYTE_W-1:0] MAIN_TX    = 8'h13;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_TX   = 3'd2
    } radio_state_e;

    typedef struct packed {
        logic        rdy_n;
        logic [2:0]  state;
        logic [3:0]  level;
    } chip_status_t;

    typedef struct packed {
        logic              rd;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } header_t;

    function automatic logic [BYTE_W-1:0] cfg_default(input int idx);
        return BYTE_W'(idx) ^ 8'hA5;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a >= WIN_LO) && (a <= WIN_HI);
    endfunction

endpackage

// File: rtl/xcvr_spi_shifter.sv
module xcvr_spi_shifter
    import xcvr_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              csn,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso,
    output logic              sel,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q, sclk_d, csn_q, mosi_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            csn_q  <= 1'b1;
            mosi_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            csn_q  <= csn;
            mosi_q <= mosi;
        end
    end

    assign sel  = ~csn_q;
    assign rise = sel &  sclk_q & ~sclk_d;
    assign fall = sel & ~sclk_q &  sclk_d;

    always_ff @(posedge clk) begin
        if (rst || csn_q) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= tx_byte;
            byte_stb <= 1'b0;
            if (rst) rx_byte <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (rise) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_q};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    byte_stb <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_q};
                end
            end
            if (fall) begin
                if (bit_cnt == '0) tx_sh <= tx_byte;
                else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sh[BYTE_W-1];

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        csn_q |=> (bit_cnt == '0));                                    // R10
    AST_BYTE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> (bit_cnt == '0));                                 // R1

endmodule

// File: rtl/xcvr_cfg_file.sv
module xcvr_cfg_file
    import xcvr_spi_pkg::*;
#(
    parameter int NUM = CFG_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [BYTE_W-1:0]     rd_data,
    output logic [NUM*BYTE_W-1:0] cfg_flat
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM - 1);

    logic [NUM*BYTE_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM; i++) begin
            if (rst || soft_rst)
                cfg_q[i*BYTE_W +: BYTE_W] <= cfg_default(i);
            else if (wr_en && (int'(wr_addr) == i))
                cfg_q[i*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= LAST) rd_data = cfg_q[int'(rd_addr)*BYTE_W +: BYTE_W];
    end

    assign cfg_flat = cfg_q;

endmodule

// File: rtl/xcvr_txfifo_level.sv
module xcvr_txfifo_level
    import xcvr_spi_pkg::*;
#(
    parameter int DEPTH = TXF_DEPTH,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic [CW-1:0]     level,
    output logic [3:0]        level_sat
);
    logic full, accept;

    assign full   = (level == CW'(DEPTH));
    assign accept = push & ~full & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) level <= '0;
        else if (accept) level <= level + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= accept;
            if (accept) wr_data <= push_data;
        end
    end

    assign level_sat = (level > CW'(15)) ? 4'hF : level[3:0];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));                                          // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !clr) |=> (!wr_valid && $stable(level)));     // R9

endmodule

// File: rtl/spi_regstrobe_slave.sv
module spi_regstrobe_slave
    import xcvr_spi_pkg::*;
#(
    parameter int NUM_CFG    = CFG_COUNT,
    parameter int FIFO_DEPTH = TXF_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      spi_sclk,
    input  logic                      spi_csn,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    output logic                      stb_reset,
    output logic                      stb_tx,
    output logic                      stb_idle,
    output logic                      stb_flush,
    output logic                      fifo_wr_valid,
    output logic [BYTE_W-1:0]         fifo_wr_data,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_flat
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              sel, byte_stb;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    header_t           rx_hdr, hdr_q;
    logic              hdr_seen, rd_done;
    logic [ADDR_W-1:0] addr_q;
    radio_state_e      state_q;
    logic [LVL_W-1:0]  level;
    logic [3:0]        level_sat;
    logic [BYTE_W-1:0] cfg_rd, stat_rd;
    chip_status_t      status;
    logic              data_stb, hdr_win, wr_ok, cfg_we, fifo_push;

    assign rx_hdr = header_t'(rx_byte);

    xcvr_spi_shifter u_shift (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
        .tx_byte(tx_byte), .miso(spi_miso), .sel(sel),
        .byte_stb(byte_stb), .rx_byte(rx_byte)
    );

    // Data-byte write decode
    assign data_stb  = sel & byte_stb & hdr_seen;
    assign hdr_win   = in_window(hdr_q.addr);
    assign wr_ok     = data_stb & ~hdr_q.rd & ~hdr_win & ~rd_done;
    assign cfg_we    = wr_ok & (addr_q != FIFO_ADDR);
    assign fifo_push = wr_ok & (addr_q == FIFO_ADDR);

    xcvr_cfg_file #(.NUM(NUM_CFG)) u_cfg (
        .clk(clk), .rst(rst), .soft_rst(stb_reset),
        .wr_en(cfg_we), .wr_addr(addr_q), .wr_data(rx_byte),
        .rd_addr(addr_q), .rd_data(cfg_rd), .cfg_flat(cfg_flat)
    );

    xcvr_txfifo_level #(.DEPTH(FIFO_DEPTH), .CW(LVL_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(stb_reset | stb_flush),
        .push(fifo_push), .push_data(rx_byte),
        .wr_valid(fifo_wr_valid), .wr_data(fifo_wr_data),
        .level(level), .level_sat(level_sat)
    );

    assign status = '{rdy_n: 1'b0, state: state_q, level: level_sat};

    always_comb begin
        case (hdr_q.addr)
            SREG_PART:  stat_rd = ID_PART;
            SREG_VER:   stat_rd = ID_VER;
            SREG_MAIN:  stat_rd = (state_q == RS_TX) ? MAIN_TX : MAIN_IDLE;
            SREG_LEVEL: stat_rd = BYTE_W'(level);
            default:    stat_rd = '0;
        endcase
    end

    // Byte loaded into the shifter at the next byte boundary
    always_comb begin
        if (!hdr_seen || !hdr_q.rd || rd_done) tx_byte = status;
        else if (hdr_win)                      tx_byte = hdr_q.burst ? stat_rd : status;
        else if (addr_q == FIFO_ADDR)          tx_byte = '0;
        else                                   tx_byte = cfg_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q     <= '0;
            hdr_seen  <= 1'b0;
            rd_done   <= 1'b0;
            addr_q    <= '0;
            state_q   <= RS_IDLE;
            stb_reset <= 1'b0;
            stb_tx    <= 1'b0;
            stb_idle  <= 1'b0;
            stb_flush <= 1'b0;
        end else begin
            stb_reset <= 1'b0;
            stb_tx    <= 1'b0;
            stb_idle  <= 1'b0;
            stb_flush <= 1'b0;
            if (!sel) begin
                hdr_seen <= 1'b0;
                rd_done  <= 1'b0;
            end else if (byte_stb && !hdr_seen) begin
                hdr_q    <= rx_hdr;
                addr_q   <= rx_hdr.addr;
                hdr_seen <= 1'b1;
                rd_done  <= 1'b0;
                if (!rx_hdr.burst && in_window(rx_hdr.addr)) begin
                    case (rx_hdr.addr)
                        CMD_RESET: begin stb_reset <= 1'b1; state_q <= RS_IDLE; end
                        CMD_TX:    begin stb_tx    <= 1'b1; state_q <= RS_TX;   end
                        CMD_IDLE:  begin stb_idle  <= 1'b1; state_q <= RS_IDLE; end
                        CMD_FLUSH: if (state_q == RS_IDLE) stb_flush <= 1'b1;
                        default: ;
                    endcase
                end
            end else if (byte_stb) begin
                if (!hdr_q.burst || hdr_win) rd_done <= 1'b1;
                else if (addr_q != FIFO_ADDR) addr_q <= addr_q + 1'b1;
            end
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_reset, stb_tx, stb_idle, stb_flush}));           // R6
    AST_FLUSH_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        stb_flush |-> (state_q == RS_IDLE));                           // R8
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        stb_reset |-> (state_q == RS_IDLE));                           // R7
    AST_HDR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (sel && byte_stb && !hdr_seen) |=> hdr_seen);                  // R2
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (data_stb && hdr_q.burst && !hdr_win && addr_q != FIFO_ADDR)
            |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));            // R3

endmodule

// File: tb/sim_spi_regstrobe_slave.sv
module sim_spi_regstrobe_slave;
    import xcvr_spi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NCFG       = CFG_COUNT;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, stb_reset, stb_tx, stb_idle, stb_flush, fifo_wr_valid;
    logic [7:0] fifo_wr_data;
    logic [NCFG*8-1:0] cfg_flat;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regstrobe_slave u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .stb_reset(stb_reset), .stb_tx(stb_tx),
        .stb_idle(stb_idle), .stb_flush(stb_flush),
        .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
        .cfg_flat(cfg_flat)
    );

    int n_tests = 0, n_fail = 0;
    int n_rst_p = 0, n_tx_p = 0, n_idle_p = 0, n_flush_p = 0, n_push = 0;
    logic [7:0] last_push = 8'h00;

    always @(posedge clk) begin
        if (stb_reset) n_rst_p++;
        if (stb_tx) n_tx_p++;
        if (stb_idle) n_idle_p++;
        if (stb_flush) n_flush_p++;
        if (fifo_wr_valid) begin n_push++; last_push = fifo_wr_data; end
    end

    logic [7:0] txb [80];
    logic [7:0] rxb [80];
    logic [7:0] m_cfg [NCFG];
    logic [2:0] m_state;
    int         m_cnt;

    function automatic logic [7:0] exp_status();
        return {1'b0, m_state, 4'((m_cnt > 15) ? 15 : m_cnt)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            sclk = 1'b1;
            rx[i] = miso;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input int nbytes);
        csn = 1'b0;
        wait_clk(4);
        for (int k = 0; k < nbytes; k++) shift_bits(txb[k], 8, rxb[k]);
        wait_clk(4);
        csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic xfer_abort(input int full, input int bits);
        logic [7:0] dummy;
        csn = 1'b0;
        wait_clk(4);
        for (int k = 0; k < full; k++) shift_bits(txb[k], 8, rxb[k]);
        shift_bits(txb[full], bits, dummy);
        wait_clk(2);
        csn = 1'b1;
        sclk = 1'b0;
        wait_clk(8);
    endtask

    task automatic read1(input logic [7:0] hdr, output logic [7:0] val);
        txb[0] = hdr; txb[1] = 8'h00;
        xfer(2);
        val = rxb[1];
    endtask

    task automatic strobe(input logic [7:0] hdr);
        txb[0] = hdr;
        xfer(1);
    endtask

    task automatic check_cfg_port(input string req);
        for (int i = 0; i < NCFG; i++) check(req, cfg_flat[i*8 +: 8], m_cfg[i]);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCFG; i++) m_cfg[i] = 8'(i) ^ 8'hA5;
        m_state = 3'd0;
        m_cnt   = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        int p0, f0;
        v = 8'($urandom(32'd4711));
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // Reset state
        check_cfg_port("R7");
        read1(8'hF0, v);
        check("R4 hdr status", rxb[0], 8'h00);
        check("R5 part", v, 8'h00);
        read1(8'hF1, v);
        check("R1 msb-first version", v, 8'h14);
        read1(8'hF5, v);
        check("R5 main idle", v, 8'h01);
        read1(8'hF2, v);
        check("R11 unlisted status", v, 8'h00);
        txb[0] = 8'hF1; txb[1] = 8'h00; txb[2] = 8'h00; xfer(3);
        check("R5 one per transaction", rxb[1], 8'h14);
        check("R5 extra byte status", rxb[2], exp_status());

        // Single write with extra bytes
        txb[0] = 8'h05; txb[1] = 8'hC3; txb[2] = 8'h77; txb[3] = 8'h99; xfer(4);
        m_cfg[5] = 8'hC3;
        for (int k = 0; k < 4; k++) check("R4 write status", rxb[k], exp_status());
        check("R2 single write", cfg_flat[5*8 +: 8], 8'hC3);
        check("R2 extra byte ignored", cfg_flat[6*8 +: 8], m_cfg[6]);
        read1(8'h85, v);
        check("R2 single read", v, 8'hC3);
        txb[0] = 8'h85; txb[1] = 0; txb[2] = 0; xfer(3);
        check("R2 read extra byte status", rxb[2], exp_status());

        // Burst write then burst read
        txb[0] = 8'h50; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'h44; xfer(5);
        m_cfg[16] = 8'h11; m_cfg[17] = 8'h22; m_cfg[18] = 8'h33; m_cfg[19] = 8'h44;
        txb[0] = 8'hD0; for (int k = 1; k <= 5; k++) txb[k] = 8'h00; xfer(6);
        for (int k = 1; k <= 5; k++) check("R3 burst read", rxb[k], m_cfg[15 + k]);

        // Unmapped reads
        read1(8'hAF, v); check("R11 addr 2F", v, 8'h00);
        read1(8'hBE, v); check("R11 addr 3E", v, 8'h00);
        read1(8'hBF, v); check("R11 addr 3F", v, 8'h00);

        // Constrained random configuration accesses
        for (int t = 0; t < 120; t++) begin
            logic b, r;
            int len, a;
            b = 1'($urandom);
            r = 1'($urandom);
            len = b ? 1 + int'($urandom % 4) : 1;
            a = int'($urandom % (NCFG - len + 1));
            txb[0] = {r, b, 6'(a)};
            for (int k = 1; k <= len; k++) txb[k] = r ? 8'h00 : 8'($urandom);
            xfer(len + 1);
            check("R4 random hdr", rxb[0], exp_status());
            for (int k = 1; k <= len; k++) begin
                if (r) check(b ? "R3 random burst read" : "R2 random read", rxb[k], m_cfg[a + k - 1]);
                else begin
                    check("R4 random write status", rxb[k], exp_status());
                    m_cfg[a + k - 1] = txb[k];
                end
            end
        end
        check_cfg_port("R2");

        // TX FIFO overflow
        p0 = n_push;
        txb[0] = 8'h7F;
        for (int k = 1; k <= 66; k++) txb[k] = 8'(k);
        xfer(67);
        for (int k = 1; k <= 66; k++)
            check("R4 level saturation", rxb[k], {4'h0, 4'(((k - 1) > 15) ? 15 : (k - 1))});
        m_cnt = 64;
        check("R9 pushes capped", n_push - p0, 64);
        check("R9 last pushed", last_push, 8'd64);
        read1(8'hFA, v);
        check("R9 level reg", v, 8'd64);
        p0 = n_push;
        txb[0] = 8'h3F; txb[1] = 8'h55; xfer(2);
        check("R9 full drop", n_push - p0, 0);

        // Flush in idle
        f0 = n_flush_p;
        strobe(8'h3B);
        m_cnt = 0;
        check("R8 flush idle pulse", n_flush_p - f0, 1);
        read1(8'hFA, v);
        check("R8 flushed level", v, 8'd0);
        check("R4 status after flush", rxb[0], exp_status());

        p0 = n_push;
        txb[0] = 8'h7F; txb[1] = 8'hAA; txb[2] = 8'hBB; txb[3] = 8'hCC; xfer(4);
        m_cnt = 3;
        check("R9 burst push", n_push - p0, 3);
        check("R9 push data", last_push, 8'hCC);

        // Transmit state and strobes
        p0 = n_tx_p;
        strobe(8'h35);
        m_state = 3'd2;
        check("R6 tx pulse", n_tx_p - p0, 1);
        read1(8'hF5, v);
        check("R6 main tx", v, 8'h13);
        check("R4 status in tx", rxb[0], 8'h23);
        f0 = n_flush_p;
        strobe(8'h3B);
        check("R8 flush refused in tx", n_flush_p - f0, 0);
        read1(8'hFA, v);
        check("R8 level kept in tx", v, 8'd3);
        p0 = n_idle_p;
        strobe(8'h36);
        m_state = 3'd0;
        check("R6 idle pulse", n_idle_p - p0, 1);
        read1(8'hF5, v);
        check("R6 main idle", v, 8'h01);

        // Abort mid-byte
        txb[0] = 8'h03; txb[1] = 8'h5A; xfer_abort(1, 5);
        read1(8'h83, v);
        check("R10 partial data dropped", v, m_cfg[3]);
        p0 = n_tx_p;
        txb[0] = 8'h35; xfer_abort(0, 4);
        check("R10 partial header dropped", n_tx_p - p0, 0);
        txb[0] = 8'h03; txb[1] = 8'h5A; xfer(2);
        m_cfg[3] = 8'h5A;
        read1(8'h83, v);
        check("R10 fresh header after abort", v, 8'h5A);

        // Reset strobe
        strobe(8'h35);
        m_state = 3'd2;
        txb[0] = 8'h08; txb[1] = 8'hEE; xfer(2);
        m_cfg[8] = 8'hEE;
        check("R2 write in tx", cfg_flat[8*8 +: 8], 8'hEE);
        p0 = n_rst_p;
        strobe(8'h30);
        model_reset();
        check("R7 reset pulse", n_rst_p - p0, 1);
        check_cfg_port("R7");
        read1(8'hF5, v);
        check("R7 state idle", v, 8'h01);
        read1(8'hFA, v);
        check("R7 fifo empty", v, 8'd0);

        summary();
    end

endmodule